// File: doc/BRIEF.md
# Pad Electrical Control with Sleep Pull Retention

This block holds the electrical settings of a row of I/O pads and turns them, together with the present power mode, into the control signals the pad cells receive. Each pad has two pull selections, one used while the chip is active and one used in any sleep mode. It also has a pull resistor-value select, a two-bit drive strength, a fast/slow slew select, a digital input enable and a usage mode (digital, analog or USB). A configuration write port loads one pad's whole settings word at a time.

The block also decides what each pad drives. While active, the core's output value and output enable go straight through. In the two light sleep modes (clock-gated and power-gated), the values from the last active cycle are held. In deep sleep, outputs are released. A parameter marks the pads whose supply is cut in deep sleep, and their pulls are turned off. Analog pads have their digital input cut. USB pads never get a pull. All pad outputs are registered, so they follow their inputs with one clock of latency.

Top module: `pad_ctrl_top`

## Requirements
- R1: Reset state. From the second clock after reset is released, with no writes, every pad shows drive strength 0, slow slew (pad_fast 0), input enable 1 and output enable 0. Pads marked in STRAP_PU show pull-up in every power mode. All other pads show no pull.
- R2: A write with cfg_we high and cfg_pad below NUM_PADS loads cfg_wdata into that pad. The bit layout is [10:9] active pull, [8:7] sleep pull, [6] resistor select, [5:4] drive strength, [3] fast slew, [2] input enable, [1:0] usage (00 digital, 01 analog, 10 USB, 11 digital). The new settings show on the outputs after the second rising edge that follows the write edge.
- R3: Pull codes are 00 none, 01 pull-up, 10 pull-down and 11 none. pad_pu and pad_pd are never both high on one pad.
- R4: pwr_mode is 00 active, 01 clock-gated, 10 power-gated and 11 deep sleep. Active mode uses the active pull code. Every other mode uses the sleep pull code.
- R5: In clock-gated and power-gated sleep, pad_do and pad_oe hold the core values sampled on the last cycle pwr_mode was active, whatever the core drives during sleep.
- R6: On the first active cycle after any sleep, pad_do and pad_oe follow the core again, with one cycle of latency.
- R7: In deep sleep, pad_oe and pad_do are 0 on every pad.
- R8: In deep sleep, pads marked in LOSE_MASK show no pull. Unmarked pads keep their sleep pull.
- R9: A pad in analog usage has pad_ie 0 whatever its input enable bit is.
- R10: A pad in USB usage shows no pull in every power mode.
- R11: pad_drv, pad_res and pad_fast show the stored fields in every power mode.
- R12: In active mode, pad_do and pad_oe equal core_out and core_oe from the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pad | input | PAD_AW | Index of the pad being written |
| cfg_wdata | input | 11 | Settings word for that pad |
| pwr_mode | input | 2 | Power mode: 00 active, 01 clock-gated, 10 power-gated, 11 deep |
| core_out | input | NUM_PADS | Output value from the core, one bit per pad |
| core_oe | input | NUM_PADS | Output enable from the core, one bit per pad |
| pad_pu | output | NUM_PADS | Pull-up enable to the pads |
| pad_pd | output | NUM_PADS | Pull-down enable to the pads |
| pad_res | output | NUM_PADS | Pull resistor-value select |
| pad_drv | output | 2*NUM_PADS | Drive strength, two bits per pad, pad 0 in the low bits |
| pad_fast | output | NUM_PADS | Fast slew select |
| pad_ie | output | NUM_PADS | Digital input enable |
| pad_oe | output | NUM_PADS | Output enable to the pads |
| pad_do | output | NUM_PADS | Output value to the pads |

## Verification
Pull selection is tried with all four pull codes spread over different pads. Active and sleep pull codes are set to opposite values, so switching power mode must visibly swap pull-up and pull-down. Output hold is tried by changing the core's values at the same moment the block enters sleep and again during sleep. This separates a real hold from a pass-through, and from a capture that is one cycle late. Deep sleep is tried with one pad that loses power and one that does not, both given a sleep pull. Analog and USB usage are each tried with settings that would otherwise enable input and pulls.

// File: rtl/pad_ctrl_pkg.sv
package pad_ctrl_pkg;
  localparam int DRV_W = 2;
  localparam int CFG_W = 11;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_CGATE  = 2'b01,
    PM_PGATE  = 2'b10,
    PM_DEEP   = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    USE_DIG   = 2'b00,
    USE_ANA   = 2'b01,
    USE_USB   = 2'b10,
    USE_DIG2  = 2'b11
  } pad_use_e;

  localparam logic [1:0] PULL_NONE = 2'b00;
  localparam logic [1:0] PULL_UP   = 2'b01;
  localparam logic [1:0] PULL_DOWN = 2'b10;

  typedef struct packed {
    logic [1:0]       act_pull;
    logic [1:0]       slp_pull;
    logic             res_sel;
    logic [DRV_W-1:0] drv;
    logic             fast;
    logic             in_en;
    logic [1:0]       usage;
  } pad_cfg_t;
endpackage

// File: rtl/pad_cfg_regs.sv
module pad_cfg_regs
  import pad_ctrl_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter int PAD_AW   = 2,
  parameter logic [NUM_PADS-1:0] STRAP_PU = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [PAD_AW-1:0] addr,
  input  logic [CFG_W-1:0]  wdata,
  output pad_cfg_t          cfg [NUM_PADS]
);
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam logic [1:0] RST_PULL = STRAP_PU[p] ? PULL_UP : PULL_NONE;
    pad_cfg_t cfg_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q.act_pull <= RST_PULL;
        cfg_q.slp_pull <= RST_PULL;
        cfg_q.res_sel  <= 1'b0;
        cfg_q.drv      <= '0;
        cfg_q.fast     <= 1'b0;
        cfg_q.in_en    <= 1'b1;
        cfg_q.usage    <= USE_DIG;
      end else if (we && (32'(addr) == p)) begin
        cfg_q <= pad_cfg_t'(wdata);
      end
    end
    assign cfg[p] = cfg_q;
  end
endmodule

// File: rtl/pad_hold.sv
module pad_hold #(
  parameter int NUM_PADS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                capture,
  input  logic [NUM_PADS-1:0] core_out,
  input  logic [NUM_PADS-1:0] core_oe,
  output logic [NUM_PADS-1:0] held_out,
  output logic [NUM_PADS-1:0] held_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held_out <= '0;
      held_oe  <= '0;
    end else if (capture) begin
      held_out <= core_out;
      held_oe  <= core_oe;
    end
  end
endmodule

// File: rtl/pad_lane.sv
module pad_lane
  import pad_ctrl_pkg::*;
#(
  parameter bit LOSES_POWER = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  pad_cfg_t         cfg,
  input  logic [1:0]       pwr_mode,
  input  logic             core_out,
  input  logic             core_oe,
  input  logic             held_out,
  input  logic             held_oe,
  output logic             pu,
  output logic             pd,
  output logic             res,
  output logic [DRV_W-1:0] drv,
  output logic             fast,
  output logic             ie,
  output logic             oe,
  output logic             dout
);
  logic       asleep, deep, pull_off;
  logic [1:0] code;
  logic       pu_n, pd_n, ie_n, oe_n, do_n;

  always_comb begin
    asleep   = (pwr_mode != PM_ACTIVE);
    deep     = (pwr_mode == PM_DEEP);
    code     = asleep ? cfg.slp_pull : cfg.act_pull;
    pull_off = (cfg.usage == USE_USB) || (deep && LOSES_POWER);
    pu_n     = !pull_off && (code == PULL_UP);
    pd_n     = !pull_off && (code == PULL_DOWN);
    ie_n     = cfg.in_en && (cfg.usage != USE_ANA);
    if (!asleep) begin
      oe_n = core_oe;
      do_n = core_out;
    end else if (deep) begin
      oe_n = 1'b0;
      do_n = 1'b0;
    end else begin
      oe_n = held_oe;
      do_n = held_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pu   <= 1'b0;
      pd   <= 1'b0;
      res  <= 1'b0;
      drv  <= '0;
      fast <= 1'b0;
      ie   <= 1'b0;
      oe   <= 1'b0;
      dout <= 1'b0;
    end else begin
      pu   <= pu_n;
      pd   <= pd_n;
      res  <= cfg.res_sel;
      drv  <= cfg.drv;
      fast <= cfg.fast;
      ie   <= ie_n;
      oe   <= oe_n;
      dout <= do_n;
    end
  end
endmodule

// File: rtl/pad_ctrl_top.sv
module pad_ctrl_top
  import pad_ctrl_pkg::*;
#(
  parameter int NUM_PADS = 4,
  parameter logic [NUM_PADS-1:0] LOSE_MASK = 4'b1000,
  parameter logic [NUM_PADS-1:0] STRAP_PU  = 4'b0001,
  localparam int PAD_AW = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [PAD_AW-1:0]         cfg_pad,
  input  logic [10:0]               cfg_wdata,
  input  logic [1:0]                pwr_mode,
  input  logic [NUM_PADS-1:0]       core_out,
  input  logic [NUM_PADS-1:0]       core_oe,
  output logic [NUM_PADS-1:0]       pad_pu,
  output logic [NUM_PADS-1:0]       pad_pd,
  output logic [NUM_PADS-1:0]       pad_res,
  output logic [2*NUM_PADS-1:0]     pad_drv,
  output logic [NUM_PADS-1:0]       pad_fast,
  output logic [NUM_PADS-1:0]       pad_ie,
  output logic [NUM_PADS-1:0]       pad_oe,
  output logic [NUM_PADS-1:0]       pad_do
);
  pad_cfg_t            cfg [NUM_PADS];
  logic [NUM_PADS-1:0] held_out, held_oe;
  logic                capture;

  assign capture = (pwr_mode == PM_ACTIVE);

  pad_cfg_regs #(
    .NUM_PADS(NUM_PADS), .PAD_AW(PAD_AW), .STRAP_PU(STRAP_PU)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_pad),
    .wdata(cfg_wdata), .cfg(cfg)
  );

  pad_hold #(.NUM_PADS(NUM_PADS)) u_hold (
    .clk(clk), .rst(rst), .capture(capture),
    .core_out(core_out), .core_oe(core_oe),
    .held_out(held_out), .held_oe(held_oe)
  );

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_lane
    pad_lane #(.LOSES_POWER(LOSE_MASK[p])) u_lane (
      .clk(clk), .rst(rst), .cfg(cfg[p]), .pwr_mode(pwr_mode),
      .core_out(core_out[p]), .core_oe(core_oe[p]),
      .held_out(held_out[p]), .held_oe(held_oe[p]),
      .pu(pad_pu[p]), .pd(pad_pd[p]), .res(pad_res[p]),
      .drv(pad_drv[2*p +: 2]), .fast(pad_fast[p]), .ie(pad_ie[p]),
      .oe(pad_oe[p]), .dout(pad_do[p])
    );
  end
endmodule

// File: rtl/pad_ctrl_chk.sv
module pad_ctrl_chk #(
  parameter int NUM_PADS = 4,
  parameter logic [NUM_PADS-1:0] LOSE_MASK = '0
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          pwr_mode,
  input logic [NUM_PADS-1:0] pad_pu,
  input logic [NUM_PADS-1:0] pad_pd,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] pad_do
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  function automatic logic light(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  assert_pull_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_pu & pad_pd) == '0);

  assert_deep_release_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(pwr_mode) == 2'b11) |-> (pad_oe == '0 && pad_do == '0));

  assert_deep_nopull_R8: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd0 && $past(pwr_mode) == 2'b11) |-> (((pad_pu | pad_pd) & LOSE_MASK) == '0));

  assert_light_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && light($past(pwr_mode)) && light($past(pwr_mode, 2)))
      |-> ($stable(pad_do) && $stable(pad_oe)));
endmodule

bind pad_ctrl_top pad_ctrl_chk #(.NUM_PADS(NUM_PADS), .LOSE_MASK(LOSE_MASK)) u_chk (
  .clk(clk), .rst(rst), .pwr_mode(pwr_mode),
  .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_oe(pad_oe), .pad_do(pad_do)
);

// File: tb/test_pad_ctrl_top.sv
module test_pad_ctrl_top;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [1:0]  cfg_pad = 0;
  logic [10:0] cfg_wdata = 0;
  logic [1:0]  pwr_mode = 0;
  logic [3:0]  core_out = 0, core_oe = 0;
  logic [3:0]  pad_pu, pad_pd, pad_res, pad_fast, pad_ie, pad_oe, pad_do;
  logic [7:0]  pad_drv;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pad_ctrl_top i_pad_ctrl_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_pad(cfg_pad), .cfg_wdata(cfg_wdata),
    .pwr_mode(pwr_mode), .core_out(core_out), .core_oe(core_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_res(pad_res), .pad_drv(pad_drv),
    .pad_fast(pad_fast), .pad_ie(pad_ie), .pad_oe(pad_oe), .pad_do(pad_do)
  );

  function automatic logic [10:0] mk(input logic [1:0] ap, input logic [1:0] sp,
      input logic res, input logic [1:0] drv, input logic fast, input logic ie,
      input logic [1:0] use_m);
    return {ap, sp, res, drv, fast, ie, use_m};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] pad, input logic [10:0] d);
    cfg_pad = pad; cfg_wdata = d; cfg_we = 1;
    step(1);
    cfg_we = 0;
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 pu", pad_pu, 4'b0001);
    chk("R1 pd", pad_pd, 0);
    chk("R1 drv", pad_drv, 0);
    chk("R1 fast", pad_fast, 0);
    chk("R1 ie", pad_ie, 4'hF);
    chk("R1 oe", pad_oe, 0);
  endtask

  task automatic t_cfg;
    wr(2'd1, mk(2'b01, 2'b00, 1, 2'd3, 1, 1, 2'b00));
    wr(2'd2, mk(2'b10, 2'b00, 0, 2'd2, 0, 1, 2'b00));
    wr(2'd3, mk(2'b11, 2'b00, 0, 2'd0, 0, 1, 2'b00));
    step(1);
    chk("R2 R3 pu", pad_pu, 4'b0011);
    chk("R2 R3 pd", pad_pd, 4'b0100);
    chk("R11 drv", pad_drv, 8'h2C);
    chk("R11 res", pad_res, 4'b0010);
    chk("R11 fast", pad_fast, 4'b0010);
  endtask

  task automatic t_sleep_pull;
    wr(2'd1, mk(2'b01, 2'b10, 1, 2'd3, 1, 1, 2'b00));
    wr(2'd2, mk(2'b10, 2'b01, 0, 2'd2, 0, 1, 2'b00));
    pwr_mode = 2'b01;
    step(2);
    chk("R4 sleep pu", pad_pu, 4'b0101);
    chk("R4 sleep pd", pad_pd, 4'b0010);
    chk("R11 sleep drv", pad_drv, 8'h2C);
    pwr_mode = 2'b00;
    step(2);
    chk("R4 active pu", pad_pu, 4'b0011);
    chk("R4 active pd", pad_pd, 4'b0100);
  endtask

  task automatic t_active;
    core_out = 4'b1010; core_oe = 4'b1100;
    step(1);
    chk("R12 do", pad_do, 4'b1010);
    chk("R12 oe", pad_oe, 4'b1100);
    core_out = 4'b0101; core_oe = 4'b0011;
    step(1);
    chk("R12 do2", pad_do, 4'b0101);
    chk("R12 oe2", pad_oe, 4'b0011);
  endtask

  task automatic t_hold;
    core_out = 4'b1011; core_oe = 4'b1111;
    step(1);
    pwr_mode = 2'b10; core_out = 4'b0000; core_oe = 4'b0000;
    step(1);
    chk("R5 entry do", pad_do, 4'b1011);
    chk("R5 entry oe", pad_oe, 4'b1111);
    core_out = 4'b0100;
    step(3);
    chk("R5 held do", pad_do, 4'b1011);
    pwr_mode = 2'b00; core_out = 4'b0110; core_oe = 4'b0110;
    step(1);
    chk("R6 wake do", pad_do, 4'b0110);
    chk("R6 wake oe", pad_oe, 4'b0110);
  endtask

  task automatic t_deep;
    wr(2'd2, mk(2'b00, 2'b10, 0, 2'd2, 0, 1, 2'b00));
    wr(2'd3, mk(2'b00, 2'b01, 0, 2'd0, 0, 1, 2'b00));
    core_out = 4'hF; core_oe = 4'hF;
    pwr_mode = 2'b11;
    step(2);
    chk("R7 deep oe", pad_oe, 0);
    chk("R7 deep do", pad_do, 0);
    chk("R8 lost pad pu", pad_pu[3], 0);
    chk("R8 kept pad pd", pad_pd[2], 1);
    chk("R8 kept strap pu", pad_pu[0], 1);
    pwr_mode = 2'b00;
    step(2);
  endtask

  task automatic t_analog;
    wr(2'd1, mk(2'b00, 2'b00, 0, 2'd0, 0, 1, 2'b01));
    wr(2'd2, mk(2'b00, 2'b00, 0, 2'd0, 0, 0, 2'b00));
    step(1);
    chk("R9 analog ie", pad_ie, 4'b1001);
  endtask

  task automatic t_usb;
    wr(2'd1, mk(2'b01, 2'b10, 0, 2'd0, 0, 1, 2'b10));
    step(1);
    chk("R10 usb active pull", {pad_pu[1], pad_pd[1]}, 0);
    pwr_mode = 2'b01;
    step(2);
    chk("R10 usb sleep pull", {pad_pu[1], pad_pd[1]}, 0);
    pwr_mode = 2'b00;
    step(2);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    step(3);
    rst = 0;
    t_reset;
    t_cfg;
    t_sleep_pull;
    t_active;
    t_hold;
    t_deep;
    t_analog;
    t_usb;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run;
    end
  end
endmodule